// File: doc/BRIEF.md
# Bank Page Tracker

This block sits between an access scheduler and the DDR2 command path. It remembers, for each of eight banks, whether a row is open and which one. Every presented access is classified against that table as a hit, a miss or a closed bank. A miss first closes the bank with a single-bank precharge and then opens the wanted row. A closed bank is opened directly. A hit goes straight to the column stage.

Each bank carries three countdown timers. The first enforces the row-to-column delay after an activate. The second enforces the precharge-to-activate gap. The third enforces the minimum time a row must stay open before it may be precharged. The refresh logic can wipe the table with a clear pulse when it precharges every bank.

The requester holds its access steady until `col_ready` pulses. That cycle is the one in which the read or write may be issued. Data movement is handled elsewhere.

Top module: `bank_page_tracker`

## Requirements
- R1: After reset every bank reads as closed and all timers read as expired. The first access to any bank is classified closed, and its activate is issued in the same cycle.
- R2: While `req_valid` is high, `req_class` reports the requested bank's state in the same cycle. The encoding is 0 for a closed bank, 1 for a hit (open with the same row) and 2 for a miss (open with another row).
- R3: For a closed bank, the block issues one activate. It sets `cmd_op` to 1, `cmd_bank` to the request bank and `cmd_addr` to the 13-bit row. From the next cycle that bank is open on that row.
- R4: For a miss, the block issues a precharge of that bank alone. It sets `cmd_op` to 2 and drives `cmd_addr` to all zeros, so bit 10 is low. The bank is closed from the next cycle, and every other bank keeps its state.
- R5: `col_ready` for a bank comes no earlier than `t_rcd` cycles after that bank's activate. A setting of 0 acts as 1.
- R6: For a hit whose row-to-column delay has passed, `col_ready` rises in the same cycle and no command is issued. `col_bank` and `col_addr` then carry the request bank and column.
- R7: An activate comes no earlier than `t_rp` cycles after the same bank's precharge. A setting of 0 acts as 1.
- R8: A precharge comes no earlier than `t_ras` cycles after the same bank's activate. A setting of 0 acts as 1.
- R9: While `clr_all` is high, no command and no `col_ready` is produced. From the next cycle every bank is closed.
- R10: A command and `col_ready` never occur in the same cycle. Neither occurs while `req_valid` is low.
- R11: An activate or precharge changes only the addressed bank's entry. An access to another bank's open row still hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access presented, held until col_ready |
| req_bank | input | 3 | Access bank |
| req_row | input | 13 | Access row |
| req_col | input | 10 | Access column |
| t_rcd | input | 5 | Activate-to-column delay in cycles |
| t_rp | input | 5 | Precharge-to-activate delay in cycles |
| t_ras | input | 5 | Activate-to-precharge delay in cycles |
| clr_all | input | 1 | All banks were precharged by refresh; invalidate table |
| cmd_valid | output | 1 | A row command is issued this cycle |
| cmd_op | output | 2 | 1 activate, 2 single-bank precharge |
| cmd_bank | output | 3 | Bank of the row command |
| cmd_addr | output | 13 | Row for activate, zero for precharge |
| col_ready | output | 1 | Column command may issue this cycle |
| col_bank | output | 3 | Bank for the column command |
| col_addr | output | 10 | Column for the column command |
| req_class | output | 2 | Classification of the present access |

## Verification
The checker watches every cycle for the three timing gaps, using its own per-bank cycle counters. It also checks that commands match the classification, that the clear pulse and an idle request keep the outputs quiet, and that a command and a column grant never coincide. The exact cycle of each command and grant is shown only by the bench, through the row and column values it carries. The same holds for the independence of banks and for the way timings of 0 and of large values stretch or shorten a miss sequence. The bench's scoreboard predicts each event from its own page model.

// File: rtl/bpt_pkg.sv
package bpt_pkg;

    typedef enum logic [1:0] {
        PG_CLOSED = 2'd0,
        PG_HIT    = 2'd1,
        PG_MISS   = 2'd2
    } page_class_t;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_ACT  = 2'd1,
        OP_PRE  = 2'd2
    } row_op_t;

    function automatic page_class_t classify(input logic is_open, input logic same_row);
        if (!is_open)
            return PG_CLOSED;
        else if (same_row)
            return PG_HIT;
        else
            return PG_MISS;
    endfunction

endpackage

// File: rtl/delay_timer.sv
module delay_timer #(
    parameter int TW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [TW-1:0] len,
    output logic          done
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= (len == '0) ? '0 : len - TW'(1);
        else if (cnt != '0)
            cnt <= cnt - TW'(1);
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/bank_slot.sv
module bank_slot #(
    parameter int ROW_W = 13,
    parameter int TW    = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             act,
    input  logic             pre,
    input  logic [ROW_W-1:0] act_row,
    input  logic [TW-1:0]    t_rcd,
    input  logic [TW-1:0]    t_rp,
    input  logic [TW-1:0]    t_ras,
    output logic             is_open,
    output logic [ROW_W-1:0] open_row,
    output logic             rcd_ok,
    output logic             rp_ok,
    output logic             ras_ok
);
    always_ff @(posedge clk) begin
        if (rst) begin
            is_open  <= 1'b0;
            open_row <= '0;
        end else if (clr) begin
            is_open  <= 1'b0;
        end else if (act) begin
            is_open  <= 1'b1;
            open_row <= act_row;
        end else if (pre) begin
            is_open  <= 1'b0;
        end
    end

    delay_timer #(.TW(TW)) u_rcd (.clk(clk), .rst(rst), .load(act), .len(t_rcd), .done(rcd_ok));
    delay_timer #(.TW(TW)) u_ras (.clk(clk), .rst(rst), .load(act), .len(t_ras), .done(ras_ok));
    delay_timer #(.TW(TW)) u_rp  (.clk(clk), .rst(rst), .load(pre), .len(t_rp),  .done(rp_ok));
endmodule

// File: rtl/cmd_select.sv
module cmd_select
    import bpt_pkg::*;
#(
    parameter int NBANK = 8,
    parameter int BA_W  = 3,
    parameter int ROW_W = 13
) (
    input  logic                        req_valid,
    input  logic [BA_W-1:0]             req_bank,
    input  logic [ROW_W-1:0]            req_row,
    input  logic                        clr,
    input  logic [NBANK-1:0]            open_vec,
    input  logic [NBANK-1:0][ROW_W-1:0] row_arr,
    input  logic [NBANK-1:0]            rcd_ok_vec,
    input  logic [NBANK-1:0]            rp_ok_vec,
    input  logic [NBANK-1:0]            ras_ok_vec,
    output page_class_t                 cls,
    output row_op_t                     op,
    output logic [NBANK-1:0]            act_vec,
    output logic [NBANK-1:0]            pre_vec,
    output logic                        col_go
);
    logic go;

    always_comb begin
        cls    = classify(open_vec[req_bank], row_arr[req_bank] == req_row);
        go     = req_valid && !clr;
        op     = OP_NONE;
        col_go = 1'b0;
        unique case (cls)
            PG_CLOSED: if (go && rp_ok_vec[req_bank])  op = OP_ACT;
            PG_MISS:   if (go && ras_ok_vec[req_bank]) op = OP_PRE;
            PG_HIT:    col_go = go && rcd_ok_vec[req_bank];
            default:   op = OP_NONE;
        endcase
        for (int b = 0; b < NBANK; b++) begin
            act_vec[b] = (op == OP_ACT) && (req_bank == BA_W'(b));
            pre_vec[b] = (op == OP_PRE) && (req_bank == BA_W'(b));
        end
    end
endmodule

// File: rtl/bank_page_tracker.sv
module bank_page_tracker
    import bpt_pkg::*;
#(
    parameter int NBANK = 8,
    parameter int BA_W  = $clog2(NBANK),
    parameter int ROW_W = 13,
    parameter int COL_W = 10,
    parameter int TW    = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [BA_W-1:0]  req_bank,
    input  logic [ROW_W-1:0] req_row,
    input  logic [COL_W-1:0] req_col,
    input  logic [TW-1:0]    t_rcd,
    input  logic [TW-1:0]    t_rp,
    input  logic [TW-1:0]    t_ras,
    input  logic             clr_all,
    output logic             cmd_valid,
    output logic [1:0]       cmd_op,
    output logic [BA_W-1:0]  cmd_bank,
    output logic [ROW_W-1:0] cmd_addr,
    output logic             col_ready,
    output logic [BA_W-1:0]  col_bank,
    output logic [COL_W-1:0] col_addr,
    output logic [1:0]       req_class
);
    logic [NBANK-1:0]            open_vec, rcd_ok_vec, rp_ok_vec, ras_ok_vec;
    logic [NBANK-1:0]            act_vec, pre_vec;
    logic [NBANK-1:0][ROW_W-1:0] row_arr;
    page_class_t                 cls;
    row_op_t                     op;
    logic                        col_go;

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        bank_slot #(.ROW_W(ROW_W), .TW(TW)) u_slot (
            .clk(clk), .rst(rst), .clr(clr_all),
            .act(act_vec[g]), .pre(pre_vec[g]), .act_row(req_row),
            .t_rcd(t_rcd), .t_rp(t_rp), .t_ras(t_ras),
            .is_open(open_vec[g]), .open_row(row_arr[g]),
            .rcd_ok(rcd_ok_vec[g]), .rp_ok(rp_ok_vec[g]), .ras_ok(ras_ok_vec[g])
        );
    end

    cmd_select #(.NBANK(NBANK), .BA_W(BA_W), .ROW_W(ROW_W)) u_sel (
        .req_valid(req_valid), .req_bank(req_bank), .req_row(req_row), .clr(clr_all),
        .open_vec(open_vec), .row_arr(row_arr),
        .rcd_ok_vec(rcd_ok_vec), .rp_ok_vec(rp_ok_vec), .ras_ok_vec(ras_ok_vec),
        .cls(cls), .op(op), .act_vec(act_vec), .pre_vec(pre_vec), .col_go(col_go)
    );

    assign cmd_valid = (op != OP_NONE);
    assign cmd_op    = op;
    assign cmd_bank  = req_bank;
    assign cmd_addr  = (op == OP_ACT) ? req_row : '0;
    assign col_ready = col_go;
    assign col_bank  = req_bank;
    assign col_addr  = req_col;
    assign req_class = cls;
endmodule

// File: rtl/bank_page_tracker_chk.sv
module bank_page_tracker_chk
    import bpt_pkg::*;
#(
    parameter int NBANK = 8,
    parameter int BA_W  = 3,
    parameter int ROW_W = 13,
    parameter int TW    = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic [BA_W-1:0]  req_bank,
    input logic [ROW_W-1:0] req_row,
    input logic [TW-1:0]    t_rcd,
    input logic [TW-1:0]    t_rp,
    input logic [TW-1:0]    t_ras,
    input logic             clr_all,
    input logic             cmd_valid,
    input logic [1:0]       cmd_op,
    input logic [BA_W-1:0]  cmd_bank,
    input logic             col_ready,
    input logic [BA_W-1:0]  col_bank,
    input logic [1:0]       req_class
);
    localparam int SW = TW + 1;

    logic [SW-1:0] since_act [NBANK];
    logic [SW-1:0] since_pre [NBANK];
    logic is_act, is_pre;

    assign is_act = cmd_valid && (cmd_op == OP_ACT);
    assign is_pre = cmd_valid && (cmd_op == OP_PRE);

    function automatic logic [SW-1:0] eff(input logic [TW-1:0] t);
        return (t == '0) ? SW'(1) : {1'b0, t};
    endfunction

    always_ff @(posedge clk) begin
        for (int b = 0; b < NBANK; b++) begin
            if (rst) begin
                since_act[b] <= '1;
                since_pre[b] <= '1;
            end else begin
                if (is_act && cmd_bank == BA_W'(b))
                    since_act[b] <= SW'(1);
                else if (since_act[b] != '1)
                    since_act[b] <= since_act[b] + SW'(1);
                if (is_pre && cmd_bank == BA_W'(b))
                    since_pre[b] <= SW'(1);
                else if (since_pre[b] != '1)
                    since_pre[b] <= since_pre[b] + SW'(1);
            end
        end
    end

    // R5
    rcd_gap_chk: assert property (@(posedge clk) disable iff (rst)
        col_ready |-> since_act[col_bank] >= eff(t_rcd));
    // R7
    rp_gap_chk: assert property (@(posedge clk) disable iff (rst)
        is_act |-> since_pre[cmd_bank] >= eff(t_rp));
    // R8
    ras_gap_chk: assert property (@(posedge clk) disable iff (rst)
        is_pre |-> since_act[cmd_bank] >= eff(t_ras));
    // R3
    act_on_closed_chk: assert property (@(posedge clk) disable iff (rst)
        is_act |-> req_class == PG_CLOSED);
    // R3
    act_opens_chk: assert property (@(posedge clk) disable iff (rst)
        is_act |=> (!req_valid || clr_all || !$stable(req_bank) || !$stable(req_row)
                    || req_class == PG_HIT));
    // R4
    pre_on_miss_chk: assert property (@(posedge clk) disable iff (rst)
        is_pre |-> req_class == PG_MISS);
    // R6
    ready_hit_chk: assert property (@(posedge clk) disable iff (rst)
        col_ready |-> req_class == PG_HIT);
    // R9
    clr_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        clr_all |-> !cmd_valid && !col_ready);
    // R9
    clr_closes_chk: assert property (@(posedge clk) disable iff (rst)
        clr_all |=> !(req_valid && req_class == PG_HIT));
    // R10
    excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(cmd_valid && col_ready));
    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |-> !cmd_valid && !col_ready);
endmodule

bind bank_page_tracker bank_page_tracker_chk #(
    .NBANK(NBANK), .BA_W(BA_W), .ROW_W(ROW_W), .TW(TW)
) u_chk (.*);

// File: tb/bank_page_tracker_test.sv
module bank_page_tracker_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [2:0]  req_bank = '0;
    logic [12:0] req_row = '0;
    logic [9:0]  req_col = '0;
    logic [4:0]  t_rcd = 5'd3, t_rp = 5'd4, t_ras = 5'd6;
    logic        clr_all = 1'b0;
    logic        cmd_valid, col_ready;
    logic [1:0]  cmd_op, req_class;
    logic [2:0]  cmd_bank, col_bank;
    logic [12:0] cmd_addr;
    logic [9:0]  col_addr;

    always #4 clk = ~clk;

    bank_page_tracker uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_bank(req_bank),
        .req_row(req_row), .req_col(req_col), .t_rcd(t_rcd), .t_rp(t_rp),
        .t_ras(t_ras), .clr_all(clr_all), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_bank(cmd_bank), .cmd_addr(cmd_addr), .col_ready(col_ready),
        .col_bank(col_bank), .col_addr(col_addr), .req_class(req_class)
    );

    typedef struct {
        int    kind;   // 0 activate, 1 precharge, 2 column grant
        int    bank;
        int    addr;
        int    cyc;
        string tag;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    bit   done = 0;

    bit open_m [8];
    int row_m  [8];
    int lact   [8];
    int lpre   [8];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int eff(input int t);
        return (t == 0) ? 1 : t;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && !done && (cmd_valid || col_ready)) begin
            int kind, addr;
            exp_t e;
            if (cmd_valid && col_ready)
                check(0, "R10", "command and grant together", 1, 0);
            kind = col_ready ? 2 : ((cmd_op == 2'd1) ? 0 : ((cmd_op == 2'd2) ? 1 : 9));
            addr = col_ready ? int'(col_addr) : int'(cmd_addr);
            if (q.size() == 0) begin
                check(0, "R10", "unexpected event kind", kind, -1);
            end else begin
                e = q.pop_front();
                check(kind == e.kind, e.tag, "event kind", kind, e.kind);
                check((col_ready ? int'(col_bank) : int'(cmd_bank)) == e.bank, e.tag, "bank",
                      col_ready ? int'(col_bank) : int'(cmd_bank), e.bank);
                check(addr == e.addr, e.tag, "address", addr, e.addr);
                check(cyc == e.cyc, e.tag, "cycle", cyc, e.cyc);
            end
        end
    end

    function automatic void push(input int kind, input int bank, input int addr,
                                 input int c, input string tag);
        exp_t e;
        e.kind = kind; e.bank = bank; e.addr = addr; e.cyc = c; e.tag = tag;
        q.push_back(e);
    endfunction

    task automatic do_req(input int b, input int r, input int c, input int nclr);
        int s, tcol, tp, ta, ecls;
        @(posedge clk); #1;
        req_valid = 1'b1;
        req_bank  = 3'(b);
        req_row   = 13'(r);
        req_col   = 10'(c);
        if (nclr > 0) begin
            clr_all = 1'b1;
            for (int k = 0; k < 8; k++) open_m[k] = 0;
            repeat (nclr) begin
                @(negedge clk);
                check(!cmd_valid && !col_ready, "R9", "quiet during clear",
                      int'(cmd_valid | col_ready), 0);
                @(posedge clk); #1;
            end
            clr_all = 1'b0;
        end
        s = cyc;
        if (open_m[b] && row_m[b] == r) begin
            ecls = 1;
            tcol = imax(s, lact[b] + eff(int'(t_rcd)));
            push(2, b, c, tcol, "R6");
        end else if (open_m[b]) begin
            ecls = 2;
            tp = imax(s, lact[b] + eff(int'(t_ras)));
            ta = tp + eff(int'(t_rp));
            tcol = ta + eff(int'(t_rcd));
            push(1, b, 0, tp, "R4");
            push(0, b, r, ta, "R7");
            push(2, b, c, tcol, "R5");
            lpre[b] = tp; lact[b] = ta; row_m[b] = r;
        end else begin
            ecls = 0;
            ta = imax(s, lpre[b] + eff(int'(t_rp)));
            tcol = ta + eff(int'(t_rcd));
            push(0, b, r, ta, "R3");
            push(2, b, c, tcol, "R5");
            lact[b] = ta; open_m[b] = 1; row_m[b] = r;
        end
        @(negedge clk);
        check(int'(req_class) == ecls, "R2", "class", int'(req_class), ecls);
        while (cyc < tcol) @(negedge clk);
    endtask

    task automatic go_idle(input int n);
        @(posedge clk); #1;
        req_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    initial begin
        for (int k = 0; k < 8; k++) begin
            open_m[k] = 0; row_m[k] = 0; lact[k] = -1000; lpre[k] = -1000;
        end
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check(!cmd_valid && !col_ready, "R1", "outputs after reset",
              int'(cmd_valid | col_ready), 0);

        // R1 R3: closed bank, activate at once
        do_req(0, 5, 1, 0);
        // R6: hit after tRCD
        do_req(0, 5, 2, 0);
        // R4 R8: miss within tRAS, then R7 and R5
        do_req(0, 9, 3, 0);
        // R11: other banks keep their rows
        do_req(1, 100, 4, 0);
        do_req(2, 200, 5, 0);
        do_req(1, 100, 6, 0);
        do_req(0, 9, 7, 0);
        // R9: clear while a request is held, then closed
        do_req(2, 200, 8, 2);
        do_req(1, 100, 9, 0);
        go_idle(3);
        check(q.size() == 0, "R10", "pending after idle", q.size(), 0);

        // zero timings act as one cycle
        go_idle(40);
        t_rcd = 5'd0; t_rp = 5'd0; t_ras = 5'd0;
        do_req(3, 7, 10, 0);
        do_req(3, 8, 11, 0);
        do_req(7, 8191, 1023, 0);
        do_req(7, 8191, 0, 0);

        // long timings and a mixed pattern
        go_idle(40);
        t_rcd = 5'd5; t_rp = 5'd2; t_ras = 5'd12;
        for (int i = 0; i < 16; i++)
            do_req((i * 3) % 8, (i * 5) % 3, i, 0);
        t_rcd = 5'd5; t_rp = 5'd2; t_ras = 5'd12;
        go_idle(5);
        check(q.size() == 0, "R10", "pending at end", q.size(), 0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    always @(posedge clk) begin
        if (!done && cyc > 20000) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog R10 actual=%0d expected<20000", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule